// File: doc/BRIEF.md
# Dual-Channel Disk Register Address Router

This block sits between a host programmed-I/O bus and the register ports of up to four drives that hang off two channels. Each host access is matched against five address windows, each a base and a fixed size. There is a command window and a control window for each channel, and one window for the bus-master registers. The access is reported back with its region, its channel and the offset inside the window. Accesses to command or control windows are forwarded to a single drive-side register port. The drive is chosen from the channel and from a per-channel master/slave bit. That bit is learned by watching host writes to the device-select register.

A 32-bit access to the data port is carried out as two back-to-back 16-bit drive transfers, lower half first. On a read, the two halves are reassembled into one 32-bit response. Accesses to bus-master registers are decoded and answered but not forwarded, since that register file lives outside this block. Accesses that miss every window, or that use a width the target does not accept, are answered with an error flag.

Top module: `disk_addr_router`

## Requirements
- R1: A window hits when its base is non-zero, addr >= base and addr - base < size. The offset reported is addr - base. When windows overlap, the first hit in the order primary command, primary control, secondary command, secondary control, bus-master wins. The region codes are 0 none, 1 command, 2 control, 3 bus-master.
- R2: In the bus-master window, an offset below BM_SPLIT (8 by default) reports channel 0, and any other offset reports channel 1. Bus-master accesses never strobe a drive and return read data 0.
- R3: A window whose base input is zero never hits, including for addresses below its size.
- R4: An address that hits no window responds with resp_err=1, region 0, channel 0, offset 0, read data 0, and no drive strobe.
- R5: The drive index equals 2*channel + the channel's select bit, where 0 is master and 1 is slave. Command and control windows of a channel use the same index.
- R6: A legal byte write to command-window offset 6 stores bit 4 of the written byte as that channel's select bit, and the write is forwarded to the newly selected drive. No other access changes a select bit.
- R7: While io_en is low, an access responds with err 0, region 0, channel 0, offset 0 and data 0. It causes no drive strobe and does not change the select bits.
- R8: A 32-bit access (size code 2) to command offset 0, the data port, makes two drive strobes on consecutive cycles with the same index and offset. The first carries data bits 15:0 and the second bits 31:16. A read returns {second half, first half}. A 16-bit access (size code 1) there makes one strobe.
- R9: The data port accepts size codes 1 and 2 only. All other command and control offsets accept only size code 0 (byte). The bus-master window accepts codes 0 to 2. Anything else responds with resp_err=1 and strobes no drive.
- R10: An access whose target drive has drive_present low makes no strobe and responds with err 0 and data 0.
- R11: Responses that reach no drive come one cycle after acceptance. A single drive transfer responds two cycles after acceptance and a split one three cycles after. req_ready is low from acceptance until the response.
- R12: After reset req_ready is 1, no strobe or response is active, and both select bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_en | input | 1 | I/O decode enable |
| base_pcmd | input | AW | Base of primary command window |
| base_pctl | input | AW | Base of primary control window |
| base_scmd | input | AW | Base of secondary command window |
| base_sctl | input | AW | Base of secondary control window |
| base_bm | input | AW | Base of bus-master window |
| drive_present | input | 4 | One bit per drive index, 1 when attached |
| req_valid | input | 1 | Host access request |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Access address |
| req_size | input | 2 | 0 byte, 1 16-bit, 2 32-bit, 3 illegal |
| req_wdata | input | HDW | Write data |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_err | output | 1 | Miss or illegal width |
| resp_region | output | 2 | Region code of the access |
| resp_chan | output | 1 | Channel of the access |
| resp_offset | output | OW | Offset inside the window |
| resp_rdata | output | HDW | Read data |
| drv_stb | output | 1 | Drive register transfer strobe |
| drv_write | output | 1 | Transfer direction |
| drv_idx | output | 2 | Target drive index |
| drv_ctl | output | 1 | 1 control window, 0 command window |
| drv_offset | output | OW | Register offset at the drive |
| drv_wdata | output | HDW/2 | Write data to drive |
| drv_rdata | input | HDW/2 | Read data from drive, sampled at the end of a strobe cycle |

## Verification
Each access takes one of three paths, and each path has a fixed response delay. A response that touches no drive comes in the cycle after acceptance. A single transfer strobes in that cycle and responds one cycle later. A split transfer strobes in two consecutive cycles and responds in the third. The bench's model turns each access into this expected schedule of strobes, ready levels and responses. It then compares every cycle up to one cycle past the response, so an early, late, missing or extra strobe or response is seen in the cycle where it happens. The drive model answers with a value that carries a running strobe count, so the order of the split halves shows in the read data.

// File: rtl/drt_pkg.sv
package drt_pkg;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_CMD  = 2'd1,
        RGN_CTL  = 2'd2,
        RGN_BM   = 2'd3
    } rgn_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } xsz_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LO   = 2'd1,
        PH_HI   = 2'd2
    } ph_e;

    localparam int NWIN = 5;
    localparam int BM_WIN = 4;

    // window order: 0 pri cmd, 1 pri ctl, 2 sec cmd, 3 sec ctl, 4 bus-master
    function automatic rgn_e win_rgn(input int i);
        if (i == BM_WIN) return RGN_BM;
        if ((i % 2) == 0) return RGN_CMD;
        return RGN_CTL;
    endfunction

    function automatic logic win_chan(input int i);
        return (i == 2) || (i == 3);
    endfunction

    function automatic int imax3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/drt_window.sv
module drt_window #(
    parameter int AW   = 16,
    parameter int OW   = 4,
    parameter int SIZE = 8
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    output logic          hit,
    output logic [OW-1:0] ofs
);
    localparam logic [AW-1:0] SZ = AW'(SIZE);

    logic [AW-1:0] diff;

    always_comb begin
        diff = addr - base;
        hit  = (base != '0) && (addr >= base) && (diff < SZ);
        ofs  = diff[OW-1:0];
    end
endmodule

// File: rtl/drt_decode.sv
module drt_decode
    import drt_pkg::*;
#(
    parameter int AW       = 16,
    parameter int OW       = 4,
    parameter int CMD_SIZE = 8,
    parameter int CTL_SIZE = 4,
    parameter int BM_SIZE  = 16,
    parameter int BM_SPLIT = 8
) (
    input  logic [AW-1:0]      addr,
    input  logic [NWIN*AW-1:0] bases,
    output rgn_e               rgn,
    output logic               chan,
    output logic [OW-1:0]      ofs
);
    logic [NWIN-1:0] hit;
    logic [OW-1:0]   wofs [NWIN];

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        localparam int WSZ = (g == BM_WIN) ? BM_SIZE :
                             ((g % 2) == 0) ? CMD_SIZE : CTL_SIZE;
        drt_window #(.AW(AW), .OW(OW), .SIZE(WSZ)) u_win (
            .addr (addr),
            .base (bases[g*AW +: AW]),
            .hit  (hit[g]),
            .ofs  (wofs[g])
        );
    end

    // scan from last to first so the lowest-numbered hit is left standing
    always_comb begin
        rgn  = RGN_NONE;
        chan = 1'b0;
        ofs  = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (hit[i]) begin
                rgn = win_rgn(i);
                ofs = wofs[i];
                if (i == BM_WIN) chan = (wofs[i] >= OW'(BM_SPLIT));
                else             chan = win_chan(i);
            end
        end
    end
endmodule

// File: rtl/drt_seq.sv
module drt_seq
    import drt_pkg::*;
#(
    parameter int OW  = 4,
    parameter int HDW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           io_en,
    input  logic [3:0]     drive_present,
    input  logic           req_valid,
    input  logic           req_write,
    input  logic [1:0]     req_size,
    input  logic [HDW-1:0] req_wdata,
    input  rgn_e           dec_rgn,
    input  logic           dec_chan,
    input  logic [OW-1:0]  dec_ofs,
    output logic           req_ready,
    output logic           resp_valid,
    output logic           resp_err,
    output logic [1:0]     resp_region,
    output logic           resp_chan,
    output logic [OW-1:0]  resp_offset,
    output logic [HDW-1:0] resp_rdata,
    output logic           drv_stb,
    output logic           drv_write,
    output logic [1:0]     drv_idx,
    output logic           drv_ctl,
    output logic [OW-1:0]  drv_offset,
    output logic [HDW/2-1:0] drv_wdata,
    input  logic [HDW/2-1:0] drv_rdata
);
    localparam int DDW       = HDW / 2;
    localparam int DPORT_OFS = 0;
    localparam int DSEL_OFS  = 6;
    localparam int DSEL_BIT  = 4;

    typedef struct packed {
        ph_e            ph;
        logic           rv;
        logic           rerr;
        rgn_e           rrgn;
        logic           rchan;
        logic [OW-1:0]  rofs;
        logic [HDW-1:0] rdata;
        logic           stb;
        logic           wr;
        logic [1:0]     idx;
        logic           ctl;
        logic [OW-1:0]  dofs;
        logic [DDW-1:0] wd;
        logic [DDW-1:0] hi_wd;
        logic [DDW-1:0] lo_rd;
        logic           split;
        logic           narrow;
        logic [1:0]     sel;
    } st_t;

    st_t st_d, st_q;

    logic           is_dport;
    logic           is_dsel;
    logic           legal;
    logic [1:0]     idx;
    logic [DDW-1:0] lo_val;
    xsz_e           xsz;

    always_comb begin
        xsz      = xsz_e'(req_size);
        is_dport = (dec_rgn == RGN_CMD) && (dec_ofs == OW'(DPORT_OFS));
        is_dsel  = (dec_rgn == RGN_CMD) && (dec_ofs == OW'(DSEL_OFS));
        if (dec_rgn == RGN_BM)  legal = (xsz != SZ_BAD);
        else if (is_dport)      legal = (xsz == SZ_HALF) || (xsz == SZ_WORD);
        else                    legal = (xsz == SZ_BYTE);

        if (st_q.wr)          lo_val = '0;
        else if (st_q.narrow) lo_val = {{(DDW-8){1'b0}}, drv_rdata[7:0]};
        else                  lo_val = drv_rdata;

        st_d     = st_q;
        st_d.rv  = 1'b0;
        st_d.stb = 1'b0;
        idx      = '0;

        unique case (st_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.rv    = 1'b1;
                    st_d.rerr  = 1'b0;
                    st_d.rrgn  = RGN_NONE;
                    st_d.rchan = 1'b0;
                    st_d.rofs  = '0;
                    st_d.rdata = '0;
                    if (io_en) begin
                        st_d.rrgn  = dec_rgn;
                        st_d.rchan = dec_chan;
                        st_d.rofs  = dec_ofs;
                        if (dec_rgn == RGN_NONE || !legal) begin
                            st_d.rerr = 1'b1;
                        end else if (dec_rgn != RGN_BM) begin
                            if (is_dsel && req_write)
                                st_d.sel[dec_chan] = req_wdata[DSEL_BIT];
                            idx = {dec_chan, st_d.sel[dec_chan]};
                            if (drive_present[idx]) begin
                                st_d.rv     = 1'b0;
                                st_d.stb    = 1'b1;
                                st_d.ph     = PH_LO;
                                st_d.wr     = req_write;
                                st_d.idx    = idx;
                                st_d.ctl    = (dec_rgn == RGN_CTL);
                                st_d.dofs   = dec_ofs;
                                st_d.wd     = is_dport ? req_wdata[DDW-1:0]
                                                       : {{(DDW-8){1'b0}}, req_wdata[7:0]};
                                st_d.hi_wd  = req_wdata[HDW-1:DDW];
                                st_d.split  = is_dport && (xsz == SZ_WORD);
                                st_d.narrow = !is_dport;
                            end
                        end
                    end
                end
            end
            PH_LO: begin
                st_d.lo_rd = lo_val;
                if (st_q.split) begin
                    st_d.stb = 1'b1;
                    st_d.wd  = st_q.hi_wd;
                    st_d.ph  = PH_HI;
                end else begin
                    st_d.rv    = 1'b1;
                    st_d.rdata = {{(HDW-DDW){1'b0}}, lo_val};
                    st_d.ph    = PH_IDLE;
                end
            end
            PH_HI: begin
                st_d.rv    = 1'b1;
                st_d.rdata = st_q.wr ? '0 : {drv_rdata, st_q.lo_rd};
                st_d.ph    = PH_IDLE;
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready   = (st_q.ph == PH_IDLE);
    assign resp_valid  = st_q.rv;
    assign resp_err    = st_q.rerr;
    assign resp_region = st_q.rrgn;
    assign resp_chan   = st_q.rchan;
    assign resp_offset = st_q.rofs;
    assign resp_rdata  = st_q.rdata;
    assign drv_stb     = st_q.stb;
    assign drv_write   = st_q.wr;
    assign drv_idx     = st_q.idx;
    assign drv_ctl     = st_q.ctl;
    assign drv_offset  = st_q.dofs;
    assign drv_wdata   = st_q.wd;

    // a strobe only ever targets an attached drive
    assert_stb_present_R10: assert property (@(posedge clk) disable iff (!rst_n)
        drv_stb |-> drive_present[drv_idx]);

    // the upper half follows a lower-half strobe on the very next cycle
    assert_hi_after_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_HI) |-> ($past(st_q.ph) == PH_LO) && $past(drv_stb) && drv_stb);

    // nothing new is accepted while a drive transfer is in flight
    assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        drv_stb |-> !req_ready && !resp_valid);

    // error responses never follow a drive transfer
    assert_err_direct_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_err) |-> ($past(st_q.ph) == PH_IDLE) && !$past(drv_stb));

    // select bits move only on an accepted write with decode enabled
    assert_sel_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready && req_write && io_en) |=> $stable(st_q.sel));

    // disabled decode gives an empty, error-free response
    assert_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !io_en) |=>
            resp_valid && !resp_err && !drv_stb && (resp_region == 2'd0));
endmodule

// File: rtl/disk_addr_router.sv
module disk_addr_router
    import drt_pkg::*;
#(
    parameter int AW       = 16,
    parameter int HDW      = 32,
    parameter int CMD_SIZE = 8,
    parameter int CTL_SIZE = 4,
    parameter int BM_SIZE  = 16,
    parameter int BM_SPLIT = 8,
    localparam int OW      = $clog2(imax3(CMD_SIZE, CTL_SIZE, BM_SIZE))
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_en,
    input  logic [AW-1:0]    base_pcmd,
    input  logic [AW-1:0]    base_pctl,
    input  logic [AW-1:0]    base_scmd,
    input  logic [AW-1:0]    base_sctl,
    input  logic [AW-1:0]    base_bm,
    input  logic [3:0]       drive_present,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [1:0]       req_size,
    input  logic [HDW-1:0]   req_wdata,
    output logic             resp_valid,
    output logic             resp_err,
    output logic [1:0]       resp_region,
    output logic             resp_chan,
    output logic [OW-1:0]    resp_offset,
    output logic [HDW-1:0]   resp_rdata,
    output logic             drv_stb,
    output logic             drv_write,
    output logic [1:0]       drv_idx,
    output logic             drv_ctl,
    output logic [OW-1:0]    drv_offset,
    output logic [HDW/2-1:0] drv_wdata,
    input  logic [HDW/2-1:0] drv_rdata
);
    rgn_e          dec_rgn;
    logic          dec_chan;
    logic [OW-1:0] dec_ofs;

    drt_decode #(
        .AW(AW), .OW(OW), .CMD_SIZE(CMD_SIZE), .CTL_SIZE(CTL_SIZE),
        .BM_SIZE(BM_SIZE), .BM_SPLIT(BM_SPLIT)
    ) u_dec (
        .addr  (req_addr),
        .bases ({base_bm, base_sctl, base_scmd, base_pctl, base_pcmd}),
        .rgn   (dec_rgn),
        .chan  (dec_chan),
        .ofs   (dec_ofs)
    );

    drt_seq #(.OW(OW), .HDW(HDW)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .io_en         (io_en),
        .drive_present (drive_present),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_size      (req_size),
        .req_wdata     (req_wdata),
        .dec_rgn       (dec_rgn),
        .dec_chan      (dec_chan),
        .dec_ofs       (dec_ofs),
        .req_ready     (req_ready),
        .resp_valid    (resp_valid),
        .resp_err      (resp_err),
        .resp_region   (resp_region),
        .resp_chan     (resp_chan),
        .resp_offset   (resp_offset),
        .resp_rdata    (resp_rdata),
        .drv_stb       (drv_stb),
        .drv_write     (drv_write),
        .drv_idx       (drv_idx),
        .drv_ctl       (drv_ctl),
        .drv_offset    (drv_offset),
        .drv_wdata     (drv_wdata),
        .drv_rdata     (drv_rdata)
    );
endmodule

// File: tb/disk_addr_router_test.sv
module disk_addr_router_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_en = 1'b0;
    logic [15:0] base_pcmd = 16'h01F0, base_pctl = 16'h03F4;
    logic [15:0] base_scmd = 16'h0170, base_sctl = 16'h0374, base_bm = 16'hC000;
    logic [3:0]  drive_present = 4'b1111;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, resp_valid, resp_err, resp_chan;
    logic [1:0]  resp_region;
    logic [3:0]  resp_offset;
    logic [31:0] resp_rdata;
    logic        drv_stb, drv_write, drv_ctl;
    logic [1:0]  drv_idx;
    logic [3:0]  drv_offset;
    logic [15:0] drv_wdata, drv_rdata;
    logic [7:0]  stb_cnt = '0;

    int checks = 0;
    int errors = 0;
    int msel [2];

    always #(PERIOD/2) clk = ~clk;

    // drive model: answer carries index, offset and a running strobe count
    assign drv_rdata = {2'b10, drv_idx, drv_offset, stb_cnt};
    always @(posedge clk) if (rst_n && drv_stb) stb_cnt <= stb_cnt + 8'd1;

    disk_addr_router uut (
        .clk(clk), .rst_n(rst_n), .io_en(io_en),
        .base_pcmd(base_pcmd), .base_pctl(base_pctl), .base_scmd(base_scmd),
        .base_sctl(base_sctl), .base_bm(base_bm), .drive_present(drive_present),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_err(resp_err), .resp_region(resp_region),
        .resp_chan(resp_chan), .resp_offset(resp_offset), .resp_rdata(resp_rdata),
        .drv_stb(drv_stb), .drv_write(drv_write), .drv_idx(drv_idx),
        .drv_ctl(drv_ctl), .drv_offset(drv_offset), .drv_wdata(drv_wdata),
        .drv_rdata(drv_rdata)
    );

    function automatic bit in_win(input logic [15:0] a, input logic [15:0] b, input int sz);
        return (b != 0) && (int'(a) >= int'(b)) && (int'(a) < int'(b) + sz);
    endfunction

    task automatic access(input bit wr, input logic [15:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, input string tag);
        int rg, ch, of, nstb, idx, c0;
        bit err, dport, legal;
        logic [31:0] exp_rd;
        logic [15:0] h0, h1;
        rg = 0; ch = 0; of = 0; err = 0; nstb = 0; idx = 0; exp_rd = 0;
        // behavioural reference: first matching window in fixed order
        if (in_win(a, base_pcmd, 8))       begin rg = 1; ch = 0; of = a - base_pcmd; end
        else if (in_win(a, base_pctl, 4))  begin rg = 2; ch = 0; of = a - base_pctl; end
        else if (in_win(a, base_scmd, 8))  begin rg = 1; ch = 1; of = a - base_scmd; end
        else if (in_win(a, base_sctl, 4))  begin rg = 2; ch = 1; of = a - base_sctl; end
        else if (in_win(a, base_bm, 16))   begin rg = 3; of = a - base_bm; ch = (of >= 8); end
        dport = (rg == 1) && (of == 0);
        if (!io_en) begin
            rg = 0; ch = 0; of = 0;
        end else if (rg == 0) begin
            err = 1;
        end else begin
            if (rg == 3) legal = (sz != 3);
            else if (dport) legal = (sz == 1) || (sz == 2);
            else legal = (sz == 0);
            if (!legal) err = 1;
            else if (rg != 3) begin
                if (wr && rg == 1 && of == 6) msel[ch] = wd[4];
                idx = 2 * ch + msel[ch];
                if (drive_present[idx]) nstb = (dport && sz == 2) ? 2 : 1;
            end
        end
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        c0 = stb_cnt;
        h0 = {2'b10, 2'(idx), 4'(of), 8'(c0)};
        h1 = {2'b10, 2'(idx), 4'(of), 8'(c0 + 1)};
        if (wr || nstb == 0) exp_rd = 0;
        else if (nstb == 2) exp_rd = {h1, h0};
        else if (dport) exp_rd = {16'h0, h0};
        else exp_rd = {24'h0, h0[7:0]};
        for (int k = 1; k <= nstb + 2; k++) begin
            bit e_stb, e_rv, e_rdy, ok;
            logic [15:0] e_wd;
            @(negedge clk);
            if (k == 1) req_valid = 1'b0;
            e_stb = (k <= nstb);
            e_rv  = (k == nstb + 1);
            e_rdy = !(k <= nstb);
            e_wd  = (k == 2) ? wd[31:16] : (dport ? wd[15:0] : {8'h0, wd[7:0]});
            ok = (drv_stb == e_stb) && (resp_valid == e_rv) && (req_ready == e_rdy);
            if (ok && e_stb)
                ok = (drv_idx == 2'(idx)) && (drv_write == wr) && (drv_ctl == (rg == 2)) &&
                     (drv_offset == 4'(of)) && (!wr || drv_wdata == e_wd);
            if (ok && e_rv)
                ok = (resp_err == err) && (resp_region == 2'(rg)) && (resp_chan == ch[0]) &&
                     (resp_offset == 4'(of)) && (resp_rdata == exp_rd);
            checks++;
            if (!ok) begin
                errors++;
                $display("FAIL %s cyc%0d: stb=%b rv=%b rdy=%b idx=%0d wd=%h err=%b rg=%0d ch=%b of=%0d rd=%h | exp stb=%b rv=%b rdy=%b idx=%0d wd=%h err=%b rg=%0d ch=%0d of=%0d rd=%h",
                    tag, k, drv_stb, resp_valid, req_ready, drv_idx, drv_wdata, resp_err,
                    resp_region, resp_chan, resp_offset, resp_rdata,
                    e_stb, e_rv, e_rdy, idx, e_wd, err, rg, ch, of, exp_rd);
            end
        end
    endtask

    initial begin
        #(PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        msel[0] = 0; msel[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (!(req_ready && !resp_valid && !drv_stb)) begin
            errors++;
            $display("FAIL R12 reset: rdy=%b rv=%b stb=%b exp 1 0 0", req_ready, resp_valid, drv_stb);
        end

        // R7: decode off, including a select write that must be dropped
        access(0, 16'h01F0, 2'd1, 32'h0, "R7 read while off");
        access(1, 16'h01F6, 2'd0, 32'h10, "R7 dsel write while off");
        io_en = 1'b1;
        access(0, 16'h01F7, 2'd0, 32'h0, "R7 R5 select unchanged after off write");

        // R1 R5: plain byte and halfword traffic on primary
        access(1, 16'h01F2, 2'd0, 32'hA5, "R1 byte write pri cmd");
        access(0, 16'h03F6, 2'd0, 32'h0, "R1 byte read pri ctl");
        access(0, 16'h01F0, 2'd1, 32'h0, "R8 half read data port");

        // R8: split transfers
        access(1, 16'h01F0, 2'd2, 32'hDEADBEEF, "R8 word write split");
        access(0, 16'h01F0, 2'd2, 32'h0, "R8 word read reassembly");

        // R6 R5: select slave on primary, then secondary master
        access(1, 16'h01F6, 2'd0, 32'hF0, "R6 select slave pri");
        access(0, 16'h01F7, 2'd0, 32'h0, "R5 read goes to drive 1");
        access(1, 16'h0176, 2'd0, 32'hE0, "R6 select master sec");
        access(0, 16'h0376, 2'd0, 32'h0, "R5 sec ctl to drive 2");
        access(0, 16'h0170, 2'd2, 32'h0, "R8 sec word read");

        // R10: absent slave on secondary
        drive_present = 4'b0111;
        access(1, 16'h0176, 2'd0, 32'h10, "R10 R6 select absent drive 3");
        access(0, 16'h0177, 2'd0, 32'h0, "R10 read absent drive");
        access(1, 16'h0170, 2'd2, 32'h12345678, "R10 word write absent");
        access(1, 16'h0176, 2'd0, 32'h00, "R6 back to master sec");
        drive_present = 4'b1111;

        // R2: bus-master split by offset
        access(0, 16'hC002, 2'd0, 32'h0, "R2 bm chan0");
        access(1, 16'hC007, 2'd2, 32'h1, "R2 bm last chan0");
        access(0, 16'hC008, 2'd1, 32'h0, "R2 bm first chan1");
        access(0, 16'hC00F, 2'd0, 32'h0, "R2 bm top chan1");

        // R4: misses
        access(0, 16'h5000, 2'd0, 32'h0, "R4 miss");
        access(1, 16'hC010, 2'd0, 32'h0, "R4 miss just past bm");

        // R9: width rules
        access(0, 16'h01F0, 2'd0, 32'h0, "R9 byte at data port");
        access(1, 16'h01F7, 2'd1, 32'h0, "R9 half at byte reg");
        access(0, 16'hC004, 2'd3, 32'h0, "R9 bad size at bm");
        access(1, 16'h03F4, 2'd2, 32'h0, "R9 word at ctl");

        // R3: zero base never hits
        base_sctl = 16'h0000;
        access(0, 16'h0002, 2'd0, 32'h0, "R3 zero base low addr");
        access(0, 16'h0376, 2'd0, 32'h0, "R3 old sctl addr now miss");
        base_sctl = 16'h0374;

        // R1: overlap resolved by window order
        base_bm = 16'h01F0;
        access(0, 16'h01F2, 2'd0, 32'h0, "R1 overlap cmd wins");
        access(0, 16'h01F9, 2'd0, 32'h0, "R1 overlap bm beyond cmd");
        base_bm = 16'hC000;

        // R11: back-to-back accesses remain correctly paced
        access(0, 16'h01F0, 2'd2, 32'h0, "R11 split then");
        access(0, 16'h5555, 2'd0, 32'h0, "R11 immediate miss");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule